// File: doc/BRIEF.md
# Receive Lane Recombiner and Symbol Filter

This block sits behind several parallel receive channels that together carry one wide stream. Each clock it takes one 10-bit symbol per lane: a control flag, a parity bit and an 8-bit payload. The lanes arrive with some skew, so the block waits for one cycle in which every participating lane shows the frame-start (JK) control code. That cycle is taken as the alignment point, and the data bytes that follow are joined into one word of `LANES` bytes per clock. With four lanes at 12.5 MHz this gives 32 bits every 80 ns.

Only data reaches the output. JK, idle and delimiter symbols are used to track the frame and are never presented as words, so the valid strobe can drive the write enable of a receive buffer directly. Each lane also has a sync-error input from its channel. A flagged lane is left out of the start and alignment decisions, and its bytes are still delivered but marked not valid in a per-lane mask. A frame with one failed lane therefore still yields useful data on the other lanes. A frame ends on a delimiter. It is cut short with an error when the lanes disagree about control versus data, or when an idle or JK replaces the delimiter. Lane parity checking can be switched on or off.

Top module: `rxr_lane_recombiner`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every output is low.
- R2: `frame_start_o` pulses one cycle after an input cycle in which every unmasked lane carries JK (bit 9 = 1, payload 8'h01) and at least one lane is unmasked, provided no frame is in progress. JK on only some unmasked lanes, even on two cycles in a row, does not start a frame.
- R3: Within a frame, an input cycle where every unmasked lane carries data (bit 9 = 0) gives `word_vld_o` one cycle later. Byte i of `word_data_o` (bits 8i+7..8i) holds lane i's payload, and lane 0 is the symbol at bits 9..0 of `lane_sym_i`.
- R4: Control symbols never produce a word, and data symbols outside a frame are ignored (no `word_vld_o`).
- R5: A lane whose `lane_cse_i` bit is high is left out of the start, end and alignment decisions. Its byte is still delivered, but its `word_lane_ok_o` bit is 0.
- R6: When `par_chk_en_i` is high, a symbol is good only if its ten bits hold an odd number of ones. A bad symbol on an unmasked lane of a word clears that lane's ok bit and pulses `err_parity_o` together with the word. When `par_chk_en_i` is low, parity has no effect.
- R7: Within a frame, a cycle where all unmasked lanes carry control symbols and at least one carries the delimiter (payload 8'h03) ends the frame: `frame_end_o` pulses one cycle later with no error.
- R8: Within a frame, a cycle where unmasked lanes mix control and data ends the frame with `err_misalign_o` and `frame_end_o` pulsing together.
- R9: Within a frame, a cycle where all unmasked lanes carry control symbols but none is a delimiter ends the frame with `err_trunc_o` and `frame_end_o`.
- R10: The input cycle right after a frame-ending cycle is ignored. A JK on all lanes there does not start a frame, and data there does not produce a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sym_i | input | LANES*10 | One symbol per lane: bit 9 control flag, bit 8 parity, bits 7..0 payload |
| lane_cse_i | input | LANES | Per-lane sync-error flag; a high bit masks that lane |
| par_chk_en_i | input | 1 | Enables odd-parity checking of lane symbols |
| word_vld_o | output | 1 | Recombined data word is valid (buffer write strobe) |
| word_data_o | output | LANES*8 | Recombined word, lane i in byte i |
| word_lane_ok_o | output | LANES | Per-lane trust mask for the current word |
| frame_start_o | output | 1 | Pulse: aligned frame start seen |
| frame_end_o | output | 1 | Pulse: frame finished, by delimiter or by error |
| err_misalign_o | output | 1 | Pulse: lanes disagreed on control versus data |
| err_trunc_o | output | 1 | Pulse: frame ended without a delimiter |
| err_parity_o | output | 1 | Pulse: an unmasked lane of the current word failed parity |

## Verification
Every result is registered once, so each output reflects the input cycle sampled at the previous rising edge. The bench drives a symbol set on the falling edge, computes from its own model what that set should produce, and compares all outputs one nanosecond after the next rising edge. The ignored cycle after a frame ends is checked one edge further on: the bench drives a full JK set, or data, into that cycle and confirms that no start pulse and no word appears on the following edge. The directed skew case keeps a JK on one lane for two cycles and checks that the start pulse first appears one edge after the cycle in which every lane shows JK.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int PAY_W = 8;
  localparam int SYM_W = PAY_W + 2;

  localparam logic [PAY_W-1:0] CODE_JK   = 8'h01;
  localparam logic [PAY_W-1:0] CODE_IDLE = 8'h02;
  localparam logic [PAY_W-1:0] CODE_END  = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_JK_ALL,
    ST_DATA,
    ST_END
  } rx_state_e;

  typedef struct packed {
    logic ctrl;
    logic jk;
    logic term;
    logic par_bad;
  } lane_cls_t;

endpackage

// File: rtl/rxr_lane_dec.sv
module rxr_lane_dec
  import rxr_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  input  logic             par_en_i,
  output lane_cls_t        cls_o,
  output logic [PAY_W-1:0] pay_o
);

  logic             is_ctrl;
  logic [PAY_W-1:0] code;

  assign is_ctrl = sym_i[SYM_W-1];
  assign code    = sym_i[PAY_W-1:0];
  assign pay_o   = code;

  // odd parity over all ten bits, parity bit included
  always_comb begin
    cls_o.ctrl    = is_ctrl;
    cls_o.jk      = is_ctrl && (code == CODE_JK);
    cls_o.term    = is_ctrl && (code == CODE_END);
    cls_o.par_bad = par_en_i && !(^sym_i);
  end

endmodule

// File: rtl/rxr_frame_fsm.sv
module rxr_frame_fsm
  import rxr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  lane_cls_t [LANES-1:0]  cls_i,
  input  logic      [LANES-1:0]  skip_i,
  output logic                   emit_o,
  output logic                   start_o,
  output logic                   stop_o,
  output logic                   mis_o,
  output logic                   trunc_o,
  output rx_state_e              state_o
);

  logic [LANES-1:0] jk_v, ctrl_v, term_v, live_v;
  logic any_live, all_jk, any_jk, all_ctrl, all_data, any_term;
  rx_state_e st, st_nx;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      jk_v[i]   = cls_i[i].jk;
      ctrl_v[i] = cls_i[i].ctrl;
      term_v[i] = cls_i[i].term;
    end
  end

  // masked lanes vote "yes" on every unanimity test and "no" on every any-test
  assign live_v   = ~skip_i;
  assign any_live = |live_v;
  assign all_jk   = any_live && (&(jk_v | skip_i));
  assign any_jk   = |(jk_v & live_v);
  assign all_ctrl = &(ctrl_v | skip_i);
  assign all_data = &(~ctrl_v | skip_i);
  assign any_term = |(term_v & live_v);

  always_comb begin
    st_nx   = st;
    emit_o  = 1'b0;
    start_o = 1'b0;
    stop_o  = 1'b0;
    mis_o   = 1'b0;
    trunc_o = 1'b0;
    case (st)
      ST_IDLE, ST_WAIT_JK_ALL: begin
        if (all_jk) begin
          st_nx   = ST_DATA;
          start_o = 1'b1;
        end else if (any_jk) begin
          st_nx = ST_WAIT_JK_ALL;
        end else begin
          st_nx = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (all_data) begin
          emit_o = 1'b1;
        end else begin
          st_nx  = ST_END;
          stop_o = 1'b1;
          if (!all_ctrl)      mis_o   = 1'b1;
          else if (!any_term) trunc_o = 1'b1;
        end
      end
      ST_END:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign state_o = st;

endmodule

// File: rtl/rxr_word_pack.sv
module rxr_word_pack
  import rxr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   emit_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   mis_i,
  input  logic                   trunc_i,
  input  logic [LANES*PAY_W-1:0] pay_i,
  input  logic [LANES-1:0]       bad_i,
  input  logic [LANES-1:0]       skip_i,
  output logic                   vld_o,
  output logic [LANES*PAY_W-1:0] data_o,
  output logic [LANES-1:0]       ok_o,
  output logic                   start_o,
  output logic                   end_o,
  output logic                   mis_o,
  output logic                   trunc_o,
  output logic                   perr_o
);

  logic [LANES-1:0] live_bad;

  assign live_bad = bad_i & ~skip_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      data_o  <= '0;
      ok_o    <= '0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
      mis_o   <= 1'b0;
      trunc_o <= 1'b0;
      perr_o  <= 1'b0;
    end else begin
      vld_o   <= emit_i;
      start_o <= start_i;
      end_o   <= stop_i;
      mis_o   <= mis_i;
      trunc_o <= trunc_i;
      perr_o  <= emit_i && (|live_bad);
      if (emit_i) begin
        data_o <= pay_i;
        ok_o   <= ~skip_i & ~bad_i;
      end
    end
  end

endmodule

// File: rtl/rxr_lane_recombiner.sv
module rxr_lane_recombiner
  import rxr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*SYM_W-1:0] lane_sym_i,
  input  logic [LANES-1:0]       lane_cse_i,
  input  logic                   par_chk_en_i,
  output logic                   word_vld_o,
  output logic [LANES*PAY_W-1:0] word_data_o,
  output logic [LANES-1:0]       word_lane_ok_o,
  output logic                   frame_start_o,
  output logic                   frame_end_o,
  output logic                   err_misalign_o,
  output logic                   err_trunc_o,
  output logic                   err_parity_o
);

  localparam int OUT_W = LANES * PAY_W;

  lane_cls_t [LANES-1:0] cls;
  logic [OUT_W-1:0]      pay;
  logic [LANES-1:0]      bad_v;
  logic                  emit, start, stop, mis, trunc;
  rx_state_e             fsm_state;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxr_lane_dec u_dec (
      .sym_i    (lane_sym_i[g*SYM_W +: SYM_W]),
      .par_en_i (par_chk_en_i),
      .cls_o    (cls[g]),
      .pay_o    (pay[g*PAY_W +: PAY_W])
    );
    assign bad_v[g] = cls[g].par_bad;
  end

  rxr_frame_fsm #(.LANES(LANES)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .cls_i   (cls),
    .skip_i  (lane_cse_i),
    .emit_o  (emit),
    .start_o (start),
    .stop_o  (stop),
    .mis_o   (mis),
    .trunc_o (trunc),
    .state_o (fsm_state)
  );

  rxr_word_pack #(.LANES(LANES)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .emit_i  (emit),
    .start_i (start),
    .stop_i  (stop),
    .mis_i   (mis),
    .trunc_i (trunc),
    .pay_i   (pay),
    .bad_i   (bad_v),
    .skip_i  (lane_cse_i),
    .vld_o   (word_vld_o),
    .data_o  (word_data_o),
    .ok_o    (word_lane_ok_o),
    .start_o (frame_start_o),
    .end_o   (frame_end_o),
    .mis_o   (err_misalign_o),
    .trunc_o (err_trunc_o),
    .perr_o  (err_parity_o)
  );

endmodule

// File: rtl/rxr_lane_recombiner_chk.sv
module rxr_lane_recombiner_chk
  import rxr_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_cse_i,
  input logic             word_vld_o,
  input logic [LANES-1:0] word_lane_ok_o,
  input logic             frame_start_o,
  input logic             frame_end_o,
  input logic             err_misalign_o,
  input logic             err_trunc_o,
  input logic             err_parity_o,
  input rx_state_e        state
);

  assert_start_enters_data_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (!word_vld_o && state == ST_DATA));

  assert_word_only_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> (state == ST_DATA));

  assert_masked_lane_flagged_R5: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> ((word_lane_ok_o & $past(lane_cse_i)) == '0));

  assert_parity_with_word_R6: assert property (@(posedge clk) disable iff (rst)
    err_parity_o |-> word_vld_o);

  assert_end_not_word_R7: assert property (@(posedge clk) disable iff (rst)
    !(word_vld_o && frame_end_o));

  assert_misalign_ends_R8: assert property (@(posedge clk) disable iff (rst)
    err_misalign_o |-> frame_end_o);

  assert_trunc_ends_R9: assert property (@(posedge clk) disable iff (rst)
    err_trunc_o |-> (frame_end_o && !err_misalign_o));

  assert_gap_after_end_R10: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> (!word_vld_o && !frame_start_o));

endmodule

bind rxr_lane_recombiner rxr_lane_recombiner_chk #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lane_cse_i     (lane_cse_i),
  .word_vld_o     (word_vld_o),
  .word_lane_ok_o (word_lane_ok_o),
  .frame_start_o  (frame_start_o),
  .frame_end_o    (frame_end_o),
  .err_misalign_o (err_misalign_o),
  .err_trunc_o    (err_trunc_o),
  .err_parity_o   (err_parity_o),
  .state          (fsm_state)
);

// File: tb/rxr_lane_recombiner_tb.sv
module rxr_lane_recombiner_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] sym_i = '0;
  logic [3:0]  cse_i = '0;
  logic        pen = 1'b0;
  logic        vld, st, en, mis, tr, pe;
  logic [31:0] data;
  logic [3:0]  ok;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int ms = 0;               // model: 0 idle, 1 wait, 2 data, 3 end
  logic [31:0] m_data = '0;
  logic [3:0]  m_ok = '0;

  always #4 clk = ~clk;

  rxr_lane_recombiner #(.LANES(4)) u_dut (
    .clk(clk), .rst(rst), .lane_sym_i(sym_i), .lane_cse_i(cse_i),
    .par_chk_en_i(pen), .word_vld_o(vld), .word_data_o(data),
    .word_lane_ok_o(ok), .frame_start_o(st), .frame_end_o(en),
    .err_misalign_o(mis), .err_trunc_o(tr), .err_parity_o(pe)
  );

  function automatic logic [9:0] mk(bit c, logic [7:0] p, bit flip);
    logic [9:0] s;
    s = {c, 1'b0, p};
    s[8] = ~(^{c, p}) ^ flip;
    return s;
  endfunction

  function automatic logic [39:0] all4(logic [9:0] s);
    return {s, s, s, s};
  endfunction

  task automatic chk(bit good, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [39:0] w, input logic [3:0] cse, input bit pe_en);
    bit e_vld = 0, e_st = 0, e_en = 0, e_mis = 0, e_tr = 0, e_pe = 0;
    bit alljk, anyjk, allc, alld, anyend;
    logic [3:0] bd;
    @(negedge clk);
    sym_i = w; cse_i = cse; pen = pe_en;
    alljk = (cse != 4'hf); anyjk = 0; allc = 1; alld = 1; anyend = 0; bd = '0;
    for (int i = 0; i < 4; i++) begin
      logic [9:0] s;
      s = w[10*i +: 10];
      if (pe_en && (^s) == 1'b0) bd[i] = 1'b1;
      if (!cse[i]) begin
        if (s[9] && s[7:0] == 8'h01) anyjk = 1; else alljk = 0;
        if (s[9]) alld = 0; else allc = 0;
        if (s[9] && s[7:0] == 8'h03) anyend = 1;
      end
    end
    case (ms)
      0, 1: begin
        if (alljk) begin ms = 2; e_st = 1; end
        else if (anyjk) ms = 1;
        else ms = 0;
      end
      2: begin
        if (alld) begin
          e_vld = 1;
          for (int i = 0; i < 4; i++) m_data[8*i +: 8] = w[10*i +: 8];
          m_ok = ~cse & ~bd;
          e_pe = |(bd & ~cse);
        end else begin
          ms = 3; e_en = 1;
          if (!allc) e_mis = 1;
          else if (!anyend) e_tr = 1;
        end
      end
      default: ms = 0;
    endcase
    @(posedge clk); #1;
    chk(vld == e_vld, "R3 word_vld", 32'(vld), 32'(e_vld));
    if (e_vld) begin
      chk(data == m_data, "R3 word_data", data, m_data);
      chk(ok == m_ok, "R5 lane_ok", 32'(ok), 32'(m_ok));
    end
    chk(st == e_st, "R2 frame_start", 32'(st), 32'(e_st));
    chk(en == e_en, "R7 frame_end", 32'(en), 32'(e_en));
    chk(mis == e_mis, "R8 misalign", 32'(mis), 32'(e_mis));
    chk(tr == e_tr, "R9 trunc", 32'(tr), 32'(e_tr));
    chk(pe == e_pe, "R6 parity", 32'(pe), 32'(e_pe));
  endtask

  task automatic rnd_frame();
    int n = 1 + $urandom_range(0, 12);
    logic [3:0] skew = 4'($urandom);
    logic [3:0] cse = ($urandom_range(0, 5) == 0) ? (4'b1 << $urandom_range(0, 3)) : 4'b0;
    bit pe_en = bit'($urandom_range(0, 1));
    logic [39:0] w;
    repeat ($urandom_range(1, 3)) step(all4(mk(1, 8'h02, 0)), cse, pe_en);
    if (skew != 0) begin
      for (int i = 0; i < 4; i++)
        w[10*i +: 10] = skew[i] ? mk(1, 8'h01, 0) : mk(1, 8'h02, 0);
      step(w, cse, pe_en);
    end
    step(all4(mk(1, 8'h01, 0)), cse, pe_en);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 4; i++)
        w[10*i +: 10] = mk(0, 8'($urandom), $urandom_range(0, 15) == 0);
      if ($urandom_range(0, 39) == 0) w[10*$urandom_range(0, 3) +: 10] = mk(1, 8'h02, 0);
      for (int i = 0; i < 4; i++)
        if (cse[i] && $urandom_range(0, 1) == 1) w[10*i +: 10] = 10'($urandom);
      step(w, cse, pe_en);
    end
    case ($urandom_range(0, 9))
      0: step(all4(mk(1, 8'h02, 0)), cse, pe_en);
      1: begin
        for (int i = 0; i < 4; i++)
          w[10*i +: 10] = (i == 0) ? mk(1, 8'h03, 0) : mk(1, 8'h02, 0);
        step(w, cse, pe_en);
      end
      default: step(all4(mk(1, 8'h03, 0)), cse, pe_en);
    endcase
    step(all4(mk(1, 8'h02, 0)), cse, pe_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] w;
    logic [9:0] JK, ID, EN;
    void'($urandom(32'd2024));
    JK = mk(1, 8'h01, 0); ID = mk(1, 8'h02, 0); EN = mk(1, 8'h03, 0);
    sym_i = all4(ID);
    repeat (3) @(posedge clk);
    #1;
    chk({vld, st, en, mis, tr, pe, ok} == '0, "R1 reset outputs", {22'b0, vld, st, en, mis, tr, pe, ok}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk({vld, st, en, mis, tr, pe, ok} == '0, "R1 after release", {22'b0, vld, st, en, mis, tr, pe, ok}, 32'h0);

    // R4: data with no frame in progress
    step({mk(0, 8'hAA, 0), mk(0, 8'hBB, 0), mk(0, 8'hCC, 0), mk(0, 8'hDD, 0)}, 4'h0, 1'b1);
    chk(vld == 0, "R4 data outside frame", 32'(vld), 0);

    // R2: single lane waits two JK cycles, never joined
    w = {ID, ID, ID, JK};
    step(w, 4'h0, 1'b1); chk(st == 0, "R2 partial JK", 32'(st), 0);
    step(w, 4'h0, 1'b1); chk(st == 0, "R2 second partial JK", 32'(st), 0);
    step(all4(ID), 4'h0, 1'b1);

    // R2/R3: skewed start then a known word
    step({ID, JK, ID, JK}, 4'h0, 1'b1);
    step(all4(JK), 4'h0, 1'b1); chk(st == 1, "R2 aligned start", 32'(st), 1);
    step({mk(0, 8'h44, 0), mk(0, 8'h33, 0), mk(0, 8'h22, 0), mk(0, 8'h11, 0)}, 4'h0, 1'b1);
    chk(vld && data == 32'h44332211, "R3 byte order", data, 32'h44332211);
    step(all4(EN), 4'h0, 1'b1); chk(en == 1 && mis == 0 && tr == 0, "R7 clean end", 32'(en), 1);

    // R10: JK right after the end is ignored, following data too
    step(all4(JK), 4'h0, 1'b1); chk(st == 0, "R10 JK in gap", 32'(st), 0);
    step(all4(mk(0, 8'h5A, 0)), 4'h0, 1'b1); chk(vld == 0, "R10 no word after gap", 32'(vld), 0);

    // R5: lane 2 masked and never sends JK
    step({JK, ID, JK, JK}, 4'b0100, 1'b1); chk(st == 1, "R5 start without masked lane", 32'(st), 1);
    step({mk(0, 8'h01, 0), ID, mk(0, 8'h03, 0), mk(0, 8'h04, 0)}, 4'b0100, 1'b1);
    chk(vld && ok == 4'b1011, "R5 masked lane flagged", 32'(ok), 32'hB);
    step(all4(EN), 4'b0100, 1'b1);
    step(all4(ID), 4'h0, 1'b1);

    // R6: parity off ignores a bad symbol; R8 misalign; R9 truncation
    step(all4(JK), 4'h0, 1'b0);
    step({mk(0, 8'h10, 1), mk(0, 8'h20, 0), mk(0, 8'h30, 0), mk(0, 8'h40, 0)}, 4'h0, 1'b0);
    chk(ok == 4'hF && pe == 0, "R6 parity disabled", 32'(ok), 32'hF);
    step({mk(0, 8'h10, 1), mk(0, 8'h20, 0), mk(0, 8'h30, 0), mk(0, 8'h40, 0)}, 4'h0, 1'b1);
    chk(ok == 4'h7 && pe == 1, "R6 parity enabled", 32'(ok), 32'h7);
    step({ID, mk(0, 8'h20, 0), mk(0, 8'h30, 0), mk(0, 8'h40, 0)}, 4'h0, 1'b1);
    chk(mis == 1 && en == 1, "R8 misalign ends frame", 32'(mis), 1);
    step(all4(ID), 4'h0, 1'b1);
    step(all4(JK), 4'h0, 1'b1);
    step(all4(ID), 4'h0, 1'b1);
    chk(tr == 1 && en == 1, "R9 truncated frame", 32'(tr), 1);
    step(all4(ID), 4'h0, 1'b1);

    for (int f = 0; f < 400; f++) rnd_frame();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule